// File: doc/BRIEF.md
# Shared-Bus I2C Master Arbitration and Status Control

This block holds the control and status state for an I2C master that has to share its bus with other masters. It watches the clock and data lines of the selected pin pair. It detects START and STOP conditions to keep a bus-busy indicator, and it holds the master-mode bit that the bit engine follows. During master transmission it checks, on every clock rising edge, that the data line reads back as high whenever the engine has released it. If the line reads low instead, another master has won arbitration. The block then drops master mode and stops pulling both lines in the same clock cycle.

Two sticky flags record the error conditions. One records lost arbitration. The other records a missing acknowledge, which the bit engine reports with a one-cycle pulse. Software clears a flag by writing 0 to it. An interrupt request is raised while any flag is set and interrupts are enabled. The I2C lines can be routed to either of two open-drain pin pairs. The second pair is refused whenever the serial port is enabled, because that port then owns those pins.

Software reaches the block through a byte-wide register bus with two registers. The CONTROL register is at address 0 and the STATUS register is at address 1.

Top module: `i2c_arb_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq` is low and no pin is pulled.
- R2: While enabled, a falling data line with the clock high sets STATUS bit 5 (busy), and a rising data line with the clock high clears it. Both lines pass through a two-stage synchronizer first.
- R3: Writing STATUS with bit 4 set while enabled, idle and not master sets STATUS bit 4 (master). Writing STATUS with bit 4 clear drops master mode.
- R4: Writing STATUS with bit 4 set while enabled, not master and with busy set leaves master clear and sets STATUS bit 7 (arbitration lost).
- R5: In master mode, a clock rising edge that samples the data line low while `eng_sda_rel` is 1 sets STATUS bit 7 and clears master. From the next cycle on, no pin is pulled.
- R6: In master mode, a clock rising edge that samples the data line low while the block itself pulls it low does not set STATUS bit 7.
- R7: An `eng_nak` pulse in master mode sets STATUS bit 6 (no acknowledge) and clears master. Outside master mode the pulse is ignored.
- R8: Writing 0 to STATUS bit 7 or bit 6 clears that flag, and writing 1 leaves it unchanged. A flag-setting event in the same cycle as the clearing write wins.
- R9: `irq` is high exactly while CONTROL bit 1 (interrupt enable) is set and STATUS bit 7 or bit 6 is set.
- R10: CONTROL bit 0 enables the block and CONTROL bit 2 selects the pin pair. Pair 1 is used only while the block is enabled, bit 2 is 1 and `sci_en` is 0. Otherwise pair 0 is used. Only the active pair is pulled, and only the active pair is watched.
- R11: Clearing CONTROL bit 0 clears master and busy, and stops all pulling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 = CONTROL, 1 = STATUS |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sci_en | input | 1 | Serial port enabled; blocks pin pair 1 |
| eng_scl_rel | input | 1 | Engine clock level: 1 releases the line, 0 pulls it low |
| eng_sda_rel | input | 1 | Engine data level: 1 releases the line, 0 pulls it low |
| eng_nak | input | 1 | One-cycle pulse: no acknowledge seen |
| master_o | output | 1 | Master mode bit |
| busy_o | output | 1 | Bus busy indicator |
| irq | output | 1 | Interrupt request |
| scl_in | input | 2 | Clock line level of each pin pair |
| sda_in | input | 2 | Data line level of each pin pair |
| scl_pull | output | 2 | Pull the clock line of a pair low |
| sda_pull | output | 2 | Pull the data line of a pair low |

## Verification
The hardest case to reach from the ports is a lost arbitration in the middle of a transfer. It needs the block in master mode with its data line released while another master holds the line low across a clock rising edge, and that edge must not also look like a START or STOP. The bench models the open-drain bus as the AND of its own external drivers and the block's pulls. It lowers the clock first, then the data line, then raises the clock, so the only event the synchronized lines show is the clock edge. The mirror case, where the block itself pulls data low, is run the same way to show that no loss is flagged.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_PAIRS = 2;

    // CONTROL register bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IE_BIT  = 1;
    localparam int CTRL_SEL_BIT = 2;

    // STATUS register bit positions
    localparam int ST_ARB_BIT  = 7;
    localparam int ST_NAK_BIT  = 6;
    localparam int ST_BUSY_BIT = 5;
    localparam int ST_MST_BIT  = 4;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic irq_en;
        logic sel;
        logic master;
        logic busy;
        logic arb;
        logic nak;
    } arb_state_t;
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Idle I2C lines are high, so every stage resets to ones.
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_arb_linemon.sv
module i2c_arb_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_prev_t;

    line_prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl;
        prev_d.sda = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_rise  = !prev_q.scl && scl;
    assign start_det = prev_q.scl && scl && prev_q.sda && !sda;
    assign stop_det  = prev_q.scl && scl && !prev_q.sda && sda;
endmodule

// File: rtl/i2c_arb_pinmux.sv
module i2c_arb_pinmux
    import i2c_arb_pkg::*;
(
    input  logic                 en,
    input  logic                 sel,
    input  logic                 sci_en,
    input  logic                 master,
    input  logic                 scl_rel,
    input  logic                 sda_rel,
    input  logic [NUM_PAIRS-1:0] scl_in,
    input  logic [NUM_PAIRS-1:0] sda_in,
    output logic [NUM_PAIRS-1:0] scl_pull,
    output logic [NUM_PAIRS-1:0] sda_pull,
    output logic                 scl_act,
    output logic                 sda_act
);
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

    logic [IDX_W-1:0] act_idx;
    logic             drive_ok;

    // The second pair is granted only when the serial port leaves it free.
    assign act_idx  = (en && sel && !sci_en) ? IDX_W'(1) : IDX_W'(0);
    assign drive_ok = en && master;

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            assign scl_pull[p] = drive_ok && (act_idx == IDX_W'(p)) && !scl_rel;
            assign sda_pull[p] = drive_ok && (act_idx == IDX_W'(p)) && !sda_rel;
        end
    endgenerate

    assign scl_act = scl_in[act_idx];
    assign sda_act = sda_in[act_idx];
endmodule

// File: rtl/i2c_arb_ctrl.sv
module i2c_arb_ctrl
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 sci_en,
    input  logic                 eng_scl_rel,
    input  logic                 eng_sda_rel,
    input  logic                 eng_nak,
    output logic                 master_o,
    output logic                 busy_o,
    output logic                 irq,
    input  logic [NUM_PAIRS-1:0] scl_in,
    input  logic [NUM_PAIRS-1:0] sda_in,
    output logic [NUM_PAIRS-1:0] scl_pull,
    output logic [NUM_PAIRS-1:0] sda_pull
);
    arb_state_t st_d, st_q;

    logic       scl_act, sda_act;
    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, start_det, stop_det;
    logic       wr_ctrl, wr_stat;

    i2c_arb_pinmux u_mux (
        .en       (st_q.en),
        .sel      (st_q.sel),
        .sci_en   (sci_en),
        .master   (st_q.master),
        .scl_rel  (eng_scl_rel),
        .sda_rel  (eng_sda_rel),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .scl_act  (scl_act),
        .sda_act  (sda_act)
    );

    i2c_arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_act, sda_act}),
        .dout  (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_arb_linemon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign wr_ctrl = reg_wr && (reg_sel_e'(reg_addr) == REG_CTRL);
    assign wr_stat = reg_wr && (reg_sel_e'(reg_addr) == REG_STAT);

    always_comb begin
        st_d = st_q;

        if (wr_ctrl) begin
            st_d.en     = reg_wdata[CTRL_EN_BIT];
            st_d.irq_en = reg_wdata[CTRL_IE_BIT];
            st_d.sel    = reg_wdata[CTRL_SEL_BIT];
        end

        if (wr_stat) begin
            if (!reg_wdata[ST_ARB_BIT]) st_d.arb = 1'b0;
            if (!reg_wdata[ST_NAK_BIT]) st_d.nak = 1'b0;
            if (reg_wdata[ST_MST_BIT]) begin
                if (!st_q.master && st_q.en) begin
                    if (st_q.busy) st_d.arb    = 1'b1;
                    else           st_d.master = 1'b1;
                end
            end else begin
                st_d.master = 1'b0;
            end
        end

        if (st_q.en) begin
            if (start_det)     st_d.busy = 1'b1;
            else if (stop_det) st_d.busy = 1'b0;
        end

        // Released data that reads low on a clock rise: another master won.
        if (st_q.master && scl_rise && eng_sda_rel && !sda_s) begin
            st_d.arb    = 1'b1;
            st_d.master = 1'b0;
        end

        if (st_q.master && eng_nak) begin
            st_d.nak    = 1'b1;
            st_d.master = 1'b0;
        end

        if (!st_d.en) begin
            st_d.master = 1'b0;
            st_d.busy   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel_e'(reg_addr) == REG_CTRL) begin
            reg_rdata[CTRL_EN_BIT]  = st_q.en;
            reg_rdata[CTRL_IE_BIT]  = st_q.irq_en;
            reg_rdata[CTRL_SEL_BIT] = st_q.sel;
        end else begin
            reg_rdata[ST_ARB_BIT]  = st_q.arb;
            reg_rdata[ST_NAK_BIT]  = st_q.nak;
            reg_rdata[ST_BUSY_BIT] = st_q.busy;
            reg_rdata[ST_MST_BIT]  = st_q.master;
        end
    end

    assign master_o = st_q.master;
    assign busy_o   = st_q.busy;
    assign irq      = (st_q.arb && st_q.irq_en) || (st_q.nak && st_q.irq_en);
endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       master,
    input logic       busy,
    input logic       arb,
    input logic       nak,
    input logic       irq_en,
    input logic       irq,
    input logic       sci_en,
    input logic       eng_nak,
    input logic       req_master,
    input logic [1:0] scl_pull,
    input logic [1:0] sda_pull
);
    // R7: a missing acknowledge in master mode ends mastership and flags it
    p_nak_drops_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master && eng_nak) |=> (!master && nak));

    // R4: a mastership request on a busy bus is refused and flagged
    p_busy_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_master && en && busy && !master) |=> (arb && !master));

    // R5: no line is pulled unless the block is master
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (scl_pull == 2'b00 && sda_pull == 2'b00));

    // R10: the serial port keeps the second pair free
    p_pair1_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en |-> (!scl_pull[1] && !sda_pull[1]));

    // R10: never both pairs pulled at once
    p_one_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_pull[0] || sda_pull[0], scl_pull[1] || sda_pull[1]}));

    // R9: a newly raised flag with interrupts enabled is visible on irq
    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && ($rose(nak) || $rose(arb))) |-> irq);

    // R11: a disabled block is never master
    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!master && !busy));
endmodule

bind i2c_arb_ctrl i2c_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (st_q.en),
    .master     (st_q.master),
    .busy       (st_q.busy),
    .arb        (st_q.arb),
    .nak        (st_q.nak),
    .irq_en     (st_q.irq_en),
    .irq        (irq),
    .sci_en     (sci_en),
    .eng_nak    (eng_nak),
    .req_master (reg_wr && reg_addr && reg_wdata[4]),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull)
);

// File: tb/i2c_arb_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_arb_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sci_en = 1'b0;
    logic       eng_scl_rel = 1'b1;
    logic       eng_sda_rel = 1'b1;
    logic       eng_nak = 1'b0;
    logic       master_o, busy_o, irq;
    logic [1:0] ext_scl = 2'b11;
    logic [1:0] ext_sda = 2'b11;
    logic [1:0] scl_in, sda_in, scl_pull, sda_pull;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Open-drain bus: any driver pulling low wins.
    assign scl_in = ext_scl & ~scl_pull;
    assign sda_in = ext_sda & ~sda_pull;

    i2c_arb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci_en(sci_en),
        .eng_scl_rel(eng_scl_rel), .eng_sda_rel(eng_sda_rel), .eng_nak(eng_nak),
        .master_o(master_o), .busy_o(busy_o), .irq(irq),
        .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    function automatic logic [7:0] stat_byte(input bit arb, input bit nak,
                                             input bit busy, input bit mst);
        return {arb, nak, busy, mst, 4'b0000};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input bit a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_nak();
        @(negedge clk); eng_nak = 1'b1;
        @(negedge clk); eng_nak = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        ext_scl = 2'b11; ext_sda = 2'b11;
        eng_scl_rel = 1'b1; eng_sda_rel = 1'b1; sci_en = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit m_arb, m_nak, m_busy, m_mst, m_ie;
        do_reset();

        // R1 reset state
        chk_reg("R1 control", 1'b0, 8'h00);
        chk_reg("R1 status", 1'b1, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 pulls", {4'd0, scl_pull, sda_pull}, 8'h00);

        // R2 busy from a START on pair 0, R4 request while busy
        wr(1'b0, 8'h01);
        ext_sda[0] = 1'b0; settle();
        chk_reg("R2 start sets busy", 1'b1, 8'h20);
        wr(1'b1, 8'h10); settle();
        chk_reg("R4 request while busy", 1'b1, 8'hA0);
        ext_sda[0] = 1'b1; settle();
        chk_reg("R2 stop clears busy", 1'b1, 8'h80);
        wr(1'b1, 8'h00);
        chk_reg("R8 write 0 clears arb", 1'b1, 8'h00);

        // R3 mastership on idle bus, R5 lost arbitration on clock rise
        wr(1'b1, 8'h10);
        chk_reg("R3 master granted", 1'b1, 8'h10);
        ext_scl[0] = 1'b0; settle();
        ext_sda[0] = 1'b0; settle();
        ext_scl[0] = 1'b1; settle();
        chk_reg("R5 mismatch flags arb", 1'b1, 8'h80);
        eng_sda_rel = 1'b0; @(negedge clk); #1;
        check("R5 data released", {6'd0, sda_pull}, 8'h00);
        eng_sda_rel = 1'b1;
        ext_sda[0] = 1'b1; settle();
        wr(1'b1, 8'hC0);
        chk_reg("R8 write 1 keeps arb", 1'b1, 8'h80);
        wr(1'b1, 8'h40);
        chk_reg("R8 clear arb keeps nak 0", 1'b1, 8'h00);

        // R6 own low drive is no loss
        wr(1'b1, 8'h10);
        eng_sda_rel = 1'b0; settle();
        check("R10 pair0 pulled", {6'd0, sda_pull}, 8'h01);
        ext_scl[0] = 1'b0; settle();
        ext_scl[0] = 1'b1; settle();
        chk_reg("R6 no false arb", 1'b1, 8'h30);
        eng_sda_rel = 1'b1; settle();
        chk_reg("R6 own stop", 1'b1, 8'h10);

        // R7 no-acknowledge
        pulse_nak(); settle();
        chk_reg("R7 nak in master", 1'b1, 8'h40);
        wr(1'b1, 8'h80);
        pulse_nak(); settle();
        chk_reg("R7 nak ignored outside master", 1'b1, 8'h00);

        // R9 interrupt
        wr(1'b1, 8'h10); pulse_nak(); settle();
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(1'b0, 8'h03); #1;
        check("R9 irq enabled", {7'd0, irq}, 8'h01);
        wr(1'b1, 8'h00); #1;
        check("R9 irq cleared", {7'd0, irq}, 8'h00);

        // R10 routing, R11 disable
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h10);
        eng_sda_rel = 1'b0; @(negedge clk); #1;
        check("R10 pair1 pulled", {6'd0, sda_pull}, 8'h02);
        sci_en = 1'b1; @(negedge clk); #1;
        check("R10 serial port blocks pair1", {6'd0, sda_pull}, 8'h01);
        wr(1'b0, 8'h00); #1;
        check("R11 disable stops pulls", {4'd0, scl_pull, sda_pull}, 8'h00);
        chk_reg("R11 disable clears state", 1'b1, 8'h00);
        eng_sda_rel = 1'b1; sci_en = 1'b0; settle();
        wr(1'b0, 8'h05); settle();
        ext_sda[0] = 1'b0; settle();
        chk_reg("R10 inactive pair ignored", 1'b1, 8'h00);
        ext_sda[0] = 1'b1; settle();
        ext_sda[1] = 1'b0; settle();
        chk_reg("R10 pair1 start watched", 1'b1, 8'h20);
        ext_sda[1] = 1'b1; settle();
        chk_reg("R10 pair1 stop watched", 1'b1, 8'h00);

        // Random mix against a bench model
        do_reset();
        void'($urandom(32'h5EED_1234));
        m_arb = 0; m_nak = 0; m_busy = 0; m_mst = 0; m_ie = 1;
        wr(1'b0, 8'h03);
        for (int i = 0; i < 200; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 4);
            case (op)
                0, 1: begin
                    d = 8'($urandom());
                    wr(1'b1, d);
                    if (!d[7]) m_arb = 0;
                    if (!d[6]) m_nak = 0;
                    if (d[4]) begin
                        if (!m_mst) begin
                            if (m_busy) m_arb = 1; else m_mst = 1;
                        end
                    end else m_mst = 0;
                end
                2: begin
                    pulse_nak();
                    if (m_mst) begin m_nak = 1; m_mst = 0; end
                end
                3: begin
                    if (ext_sda[0]) begin ext_sda[0] = 1'b0; m_busy = 1; end
                end
                default: begin
                    if (!ext_sda[0]) begin ext_sda[0] = 1'b1; m_busy = 0; end
                end
            endcase
            settle();
            chk_reg("R2 R3 R4 R7 R8 random status", 1'b1, stat_byte(m_arb, m_nak, m_busy, m_mst));
            check("R9 random irq", {7'd0, irq}, {7'd0, m_ie && (m_arb || m_nak)});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule